// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This is a purely combinational helper for the execute stage of an 8-bit processor. It handles the single-register operations that move bits around inside a byte: circular rotates, rotates through the carry flag, arithmetic and logical shifts, nibble exchange, and the test of one chosen bit. It also covers the short rotate forms that work only on the accumulator. Those forms differ from the long forms only in how they set the zero flag.

The core presents an operation code, the operand byte, a bit index and the current four-flag nibble. In the same cycle the unit returns the new byte, a strobe that says whether that byte should be written back, and the updated flag nibble. The core fetches any memory operand and counts cycles itself.

Top module: `rsb_unit`

## Requirements
- R1: The flag nibble is laid out as bit 3 Zero, bit 2 Subtract, bit 1 Half-carry and bit 0 Carry. The operation codes are 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SWAP, 7 SRL, 8 BIT, 9 RLCA, 10 RRCA, 11 RLA and 12 RRA.
- R2: A circular left rotate moves the old bit 7 into bit 0 and into Carry. A circular right rotate moves the old bit 0 into bit 7 and into Carry.
- R3: A rotate through carry fills the vacated end bit with the incoming Carry, and the bit shifted out becomes the new Carry. The left form vacates bit 0 and the right form vacates bit 7.
- R4: An arithmetic left shift fills bit 0 with 0 and puts the old bit 7 into Carry.
- R5: An arithmetic right shift keeps bit 7 unchanged. A logical right shift fills bit 7 with 0. Both put the old bit 0 into Carry.
- R6: A swap exchanges the high and low nibbles, sets Zero from the result and clears Subtract, Half-carry and Carry.
- R7: The long rotate and shift forms (codes 0 to 7) set Zero exactly when the result is 0, and they clear Subtract and Half-carry.
- R8: The accumulator rotates (codes 9 to 12) produce the same byte and Carry as codes 0 to 3, but they force Zero, Subtract and Half-carry to 0 even when the result is 0.
- R9: A bit test sets Zero to the inverse of operand bit `bitIdx`, clears Subtract, sets Half-carry and keeps Carry. Its write strobe is low and its result equals the operand.
- R10: Codes 13 to 15 do nothing. The write strobe is low, the result equals the operand and the flags pass through unchanged.
- R11: The write strobe is high for every rotate, shift and swap code (0 to 7 and 9 to 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation select (encoding in R1) |
| operand | input | 8 | Byte to operate on |
| bitIdx | input | 3 | Bit position for the bit test |
| flagsIn | input | 4 | Current flags, laid out as in R1 |
| result | output | 8 | Rotated, shifted or swapped byte |
| resultValid | output | 1 | High when the result should be written back |
| flagsOut | output | 4 | Updated flags |

## Verification
Every operation code is driven with the operands 0x00, 0x80, 0x01, 0xFF, 0xA5 and 0x3C, once with the incoming Carry clear and once with it set. The patterns are chosen to separate specific behaviours:
- 0x80 and 0x01 show which end bit is shifted out and what fills the vacated end. They tell a circular rotate from a rotate through carry, and an arithmetic right shift from a logical one.
- 0x00 and 0xFF, combined with both Carry values, expose a result of zero. This separates the long forms, which set Zero, from the accumulator forms, which never do.
- The bit test walks all eight indices over 0xA5 and 0x5A with Carry both clear and set. This checks the bit selection and that Carry is preserved.
- The unused codes are driven with arbitrary flags to confirm that everything passes through untouched.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SWAP = 4'd6,
    OP_SRL  = 4'd7,
    OP_BIT  = 4'd8,
    OP_RLCA = 4'd9,
    OP_RRCA = 4'd10,
    OP_RLA  = 4'd11,
    OP_RRA  = 4'd12
  } rsbOpE;

  // R1: flag nibble layout, MSB first
  typedef struct packed {
    logic zero;
    logic sub;
    logic half;
    logic carry;
  } rsbFlagsT;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic isShift;   // result is produced by the shifter
    logic toLeft;    // direction of the move
    logic circ;      // the bit shifted out re-enters at the other end
    logic viaCarry;  // the incoming carry enters the vacated bit
    logic keepMsb;   // a right shift copies bit 7
    logic isSwap;    // nibble exchange
    logic isBit;     // single-bit test
    logic accForm;   // Zero is forced low
  } rsbCtrlT;

endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
(
  input  logic [3:0] opCode,
  output rsbCtrlT    ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (opCode)
      OP_RLC:  begin ctrl.isShift = 1'b1; ctrl.toLeft = 1'b1; ctrl.circ = 1'b1; end
      OP_RRC:  begin ctrl.isShift = 1'b1; ctrl.circ = 1'b1; end
      OP_RL:   begin ctrl.isShift = 1'b1; ctrl.toLeft = 1'b1; ctrl.viaCarry = 1'b1; end
      OP_RR:   begin ctrl.isShift = 1'b1; ctrl.viaCarry = 1'b1; end
      OP_SLA:  begin ctrl.isShift = 1'b1; ctrl.toLeft = 1'b1; end
      OP_SRA:  begin ctrl.isShift = 1'b1; ctrl.keepMsb = 1'b1; end
      OP_SWAP: begin ctrl.isShift = 1'b1; ctrl.isSwap = 1'b1; end
      OP_SRL:  begin ctrl.isShift = 1'b1; end
      OP_BIT:  begin ctrl.isBit = 1'b1; end
      OP_RLCA: begin ctrl.isShift = 1'b1; ctrl.toLeft = 1'b1; ctrl.circ = 1'b1; ctrl.accForm = 1'b1; end
      OP_RRCA: begin ctrl.isShift = 1'b1; ctrl.circ = 1'b1; ctrl.accForm = 1'b1; end
      OP_RLA:  begin ctrl.isShift = 1'b1; ctrl.toLeft = 1'b1; ctrl.viaCarry = 1'b1; ctrl.accForm = 1'b1; end
      OP_RRA:  begin ctrl.isShift = 1'b1; ctrl.viaCarry = 1'b1; ctrl.accForm = 1'b1; end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF  = DATA_W / 2
) (
  input  rsbCtrlT            ctrl,
  input  logic [DATA_W-1:0]  operand,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  dataOut,
  output logic               carryOut,
  output logic               selBit
);

  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] moved;
  logic              fillLo;
  logic              fillHi;
  logic              movedCarry;

  // Nibble exchange: output bit i takes the bit half a word away
  for (genvar i = 0; i < DATA_W; i++) begin : gSwap
    assign swapped[i] = operand[(i + HALF) % DATA_W];
  end

  always_comb begin
    fillLo = ctrl.circ ? operand[DATA_W-1] : (ctrl.viaCarry ? carryIn : 1'b0);
    fillHi = ctrl.circ ? operand[0]
           : ctrl.viaCarry ? carryIn
           : ctrl.keepMsb ? operand[DATA_W-1] : 1'b0;
    if (ctrl.toLeft) begin
      moved      = {operand[DATA_W-2:0], fillLo};
      movedCarry = operand[DATA_W-1];
    end else begin
      moved      = {fillHi, operand[DATA_W-1:1]};
      movedCarry = operand[0];
    end
  end

  always_comb begin
    if (!ctrl.isShift) begin
      dataOut  = operand;
      carryOut = carryIn;
    end else if (ctrl.isSwap) begin
      dataOut  = swapped;
      carryOut = 1'b0;
    end else begin
      dataOut  = moved;
      carryOut = movedCarry;
    end
  end

  assign selBit = operand[bitIdx];

  // A move by one place keeps all bits but the one shifted out
  always_comb begin
    if (ctrl.isShift && !ctrl.isSwap && ctrl.circ)
      AST_CIRC_KEEPS_ONES: assert ($countones(dataOut) == $countones(operand)); // R2
    if (ctrl.isShift && ctrl.isSwap)
      AST_SWAP_KEEPS_ONES: assert ($countones(dataOut) == $countones(operand)); // R6
  end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic [3:0]        flagsOut
);

  rsbCtrlT  ctrl;
  rsbFlagsT fIn;
  rsbFlagsT fOut;
  logic     carryOut;
  logic     selBit;

  assign fIn = rsbFlagsT'(flagsIn);

  rsb_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  rsb_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl     (ctrl),
    .operand  (operand),
    .bitIdx   (bitIdx),
    .carryIn  (fIn.carry),
    .dataOut  (result),
    .carryOut (carryOut),
    .selBit   (selBit)
  );

  always_comb begin
    fOut = fIn;
    if (ctrl.isBit) begin
      fOut.zero = ~selBit;
      fOut.sub  = 1'b0;
      fOut.half = 1'b1;
    end else if (ctrl.isShift) begin
      fOut.zero  = ctrl.accForm ? 1'b0 : (result == '0);
      fOut.sub   = 1'b0;
      fOut.half  = 1'b0;
      fOut.carry = carryOut;
    end
  end

  assign flagsOut    = fOut;
  assign resultValid = ctrl.isShift;

  always_comb begin
    if (opCode == OP_BIT) begin
      AST_BIT_NO_WRITE: assert (!resultValid); // R9
      AST_BIT_CARRY_KEPT: assert (flagsOut[0] == flagsIn[0]); // R9
    end
    if (opCode >= OP_RLCA)
      if (opCode <= OP_RRA)
        AST_ACC_ZERO_LOW: assert (flagsOut[3] == 1'b0); // R8
    if (opCode > OP_RRA)
      AST_IDLE_PASS: assert (flagsOut == flagsIn && result == operand && !resultValid); // R10
    if (resultValid)
      AST_WRITE_CLEARS_SUB: assert (flagsOut[2] == 1'b0 && flagsOut[1] == 1'b0); // R7
  end

endmodule

// File: tb/rsb_unit_tb_top.sv
module rsb_unit_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [3:0] opCode   = 4'd15;
  logic [7:0] operand  = 8'h00;
  logic [2:0] bitIdx   = 3'd0;
  logic [3:0] flagsIn  = 4'h0;
  logic [7:0] result;
  logic       resultValid;
  logic [3:0] flagsOut;

  rsb_unit dut_i (
    .opCode      (opCode),
    .operand     (operand),
    .bitIdx      (bitIdx),
    .flagsIn     (flagsIn),
    .result      (result),
    .resultValid (resultValid),
    .flagsOut    (flagsOut)
  );

  typedef struct {
    logic [7:0] res;
    logic       valid;
    logic [3:0] flags;
    string      tag;
  } expT;

  expT expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  // Expected values derived from the requirements (flags: Z N H C, R1)
  function automatic expT refModel(logic [3:0] op, logic [7:0] a, logic [2:0] idx, logic [3:0] f);
    expT e;
    logic cIn;
    logic c;
    logic [7:0] r;
    cIn = f[0];
    c = 1'b0;
    r = a;
    e.valid = 1'b1;
    case (op)
      4'd0, 4'd9:  begin r = (a << 1) | (a >> 7); c = a[7]; end
      4'd1, 4'd10: begin r = (a >> 1) | (a << 7); c = a[0]; end
      4'd2, 4'd11: begin r = (a << 1) | {7'd0, cIn}; c = a[7]; end
      4'd3, 4'd12: begin r = (a >> 1) | {cIn, 7'd0}; c = a[0]; end
      4'd4: begin r = a << 1; c = a[7]; end
      4'd5: begin r = $unsigned($signed(a) >>> 1); c = a[0]; end
      4'd6: begin r = (a << 4) | (a >> 4); c = 1'b0; end
      4'd7: begin r = a >> 1; c = a[0]; end
      default: ;
    endcase
    e.res = r;
    if (op <= 4'd7) begin
      e.flags = {(r == 8'd0), 1'b0, 1'b0, c};
      e.tag = (op <= 4'd1) ? "R2 R7 R11" : (op <= 4'd3) ? "R3 R7 R11" :
              (op == 4'd4) ? "R4 R7 R11" : (op == 4'd6) ? "R6 R7 R11" : "R5 R7 R11";
    end else if (op == 4'd8) begin
      e.valid = 1'b0;
      e.res = a;
      e.flags = {~a[idx], 1'b0, 1'b1, cIn};
      e.tag = "R9";
    end else if (op <= 4'd12) begin
      e.flags = {1'b0, 1'b0, 1'b0, c};
      e.tag = "R8 R11";
    end else begin
      e.valid = 1'b0;
      e.res = a;
      e.flags = f;
      e.tag = "R10";
    end
    return e;
  endfunction

  task automatic drive(logic [3:0] op, logic [7:0] a, logic [2:0] idx, logic [3:0] f);
    @(posedge clk);
    opCode = op;
    operand = a;
    bitIdx = idx;
    flagsIn = f;
    expQ.push_back(refModel(op, a, idx, f));
  endtask

  // Monitor: compares at the falling edge, away from input changes
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        nChecks++;
        if (result !== e.res || resultValid !== e.valid || flagsOut !== e.flags) begin
          nFails++;
          $display("FAIL %s: op=%0d a=%h idx=%0d fin=%h got res=%h v=%b f=%h exp res=%h v=%b f=%h",
                   e.tag, opCode, operand, bitIdx, flagsIn, result, resultValid, flagsOut,
                   e.res, e.valid, e.flags);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [6];
    pats = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'hA5, 8'h3C};
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Idle state after reset: unused code passes through (R10)
    drive(4'd15, 8'h00, 3'd0, 4'h0);
    // R1 encodings: every rotate/shift code with both carry-in values
    for (int op = 0; op <= 12; op++) begin
      if (op == 8) continue;
      for (int p = 0; p < 6; p++) begin
        drive(4'(op), pats[p], 3'd0, 4'b0000);
        drive(4'(op), pats[p], 3'd0, 4'b1111);
      end
    end
    // R9: bit test over every index, carry clear and set
    for (int i = 0; i < 8; i++) begin
      drive(4'd8, 8'hA5, 3'(i), 4'b0000);
      drive(4'd8, 8'h5A, 3'(i), 4'b0001);
    end
    // R10: unused codes leave everything untouched
    drive(4'd13, 8'h5C, 3'd2, 4'b1010);
    drive(4'd14, 8'h00, 3'd7, 4'b0101);
    drive(4'd15, 8'hFF, 3'd1, 4'b1111);
    // R8 corner: result zero but Zero stays low
    drive(4'd11, 8'h80, 3'd0, 4'b1110);
    drive(4'd10, 8'h00, 3'd0, 4'b1111);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule